// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a (process ID, virtual page number) pair into a physical frame number. Its translation table is indexed by physical frame, not by virtual page: there is one entry per frame, and that entry names the process and the virtual page that currently own the frame. The same table serves every resident process. To avoid a linear search, the virtual page number is hashed into an anchor table. Each anchor holds the first frame of a chain, and the entries of the chain are linked through next-pointers. The walk engine follows the chain one entry per clock. It stops on a match, on the nil pointer that ends every chain, or after a fixed number of links, which protects it against a corrupt loop.

Entries are loaded through a separate insert port. Each insert places the new frame at the head of the chain for its hash bucket. A lookup request or an insert is taken only when `ready` is high. After a request the block answers with a one-cycle `resp_valid` pulse. That pulse carries either a hit with the frame number or a miss.

Top module: `inv_pt_lookup`

## Requirements
- R1: After a synchronous active-low reset, `ready` is 1 and `resp_valid` is 0, and every anchor is nil, so any lookup misses.
- R2: The bucket is chosen by the hash `vpn[7:0] XOR vpn[15:8]`. Pages whose hashes are equal share one chain.
- R3: An insert of frame F writes the pair into entry F. The entry's next field takes the old anchor value, and the anchor becomes F. A newer entry is therefore reached before older entries in the same chain.
- R4: A lookup hits only when both the stored process ID and the stored virtual page number equal the request's values.
- R5: Reaching the nil pointer (all ones in the 9-bit pointer, value 511) reports a miss. A chain of N entries with no match answers N+1 cycles after the request is accepted.
- R6: The walk examines one entry per cycle. A hit on the n-th entry of a chain raises `resp_valid` exactly n cycles after the accepting edge, and `ready` stays 0 until then.
- R7: If 256 entries have been examined without a match or a nil pointer, the lookup reports a miss. This happens 257 cycles after acceptance.
- R8: While a walk is in progress (`ready` low), lookup requests and inserts are ignored and change no stored state.
- R9: When an insert and a lookup request are both presented while idle, the insert is performed, the request is dropped with no response, and `ready` stays 1.
- R10: `resp_valid` is a single-cycle pulse. On a hit, `resp_frame` is the frame index (0 to 255). On a miss, `resp_frame` is 511.
- R11: Virtual page bits above bit 15 do not enter the hash, but they do take part in the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_pid | input | 8 | Process ID to translate |
| req_vpn | input | 20 | Virtual page number to translate |
| ins_valid | input | 1 | Insert strobe |
| ins_frame | input | 8 | Frame whose entry is loaded |
| ins_pid | input | 8 | Process ID stored in the entry |
| ins_vpn | input | 20 | Virtual page stored in the entry |
| ready | output | 1 | Engine idle; request or insert is taken |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_hit | output | 1 | 1 on hit, 0 on miss |
| resp_frame | output | 9 | Frame on hit, 511 on miss |

## Verification
The bench builds chains with colliding hashes and checks the order in which they are searched and the exact response cycle. A design that inserts at the tail, or that spends extra cycles per link, answers in the wrong cycle or returns the wrong frame. It looks up pages whose process ID differs, or whose high VPN bits differ, to catch a design that matches on a partial key. It builds a self-loop to confirm that the walk is cut off after 256 links rather than hanging. It also drives strobes while the engine is busy, and both strobes together while idle, to catch a design that lets a lookup race an insert or that corrupts a chain mid-walk.

// File: rtl/ipt_pkg.sv
// Package: shared types for the inverted page table lookup.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ipt_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;
endpackage

// File: rtl/ipt_anchor_table.sv
// Module: ipt_anchor_table
// Holds one chain-head pointer per hash bucket. Reads are combinational
// and writes take effect at the clock edge. Reset loads every bucket
// with the nil pointer (all ones).
// Assumes a single writer; a read in the write cycle returns the old value.
module ipt_anchor_table #(
    parameter int HASH_W = 8,
    parameter int PTR_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HASH_W-1:0] rd_idx,
    output logic [PTR_W-1:0]  rd_ptr,
    input  logic              wr_en,
    input  logic [HASH_W-1:0] wr_idx,
    input  logic [PTR_W-1:0]  wr_ptr
);
    localparam int          DEPTH = 1 << HASH_W;
    localparam logic [PTR_W-1:0] NIL = {PTR_W{1'b1}};

    logic [PTR_W-1:0] heads [DEPTH];

    // Purpose: clear all buckets on reset, otherwise store a new head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                heads[i] <= NIL;
            end
        end else if (wr_en) begin
            heads[wr_idx] <= wr_ptr;
        end
    end

    assign rd_ptr = heads[rd_idx];

    // R3: a written head is visible on the next cycle when read back
    assert_head_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx) || rd_ptr == $past(wr_ptr)));
endmodule

// File: rtl/ipt_frame_table.sv
// Module: ipt_frame_table
// The inverted table: one entry per physical frame, holding the owning
// process ID, the virtual page and the next-pointer of its chain.
// Assumes entries are reached only through anchors, so they need no reset.
// A read at a pointer with the top bit set returns a blank entry whose
// next field is nil.
module ipt_frame_table #(
    parameter int FRAMES  = 256,
    parameter int FRAME_W = 8,
    parameter int PTR_W   = 9,
    parameter int PID_W   = 8,
    parameter int VPN_W   = 20
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PTR_W-1:0]   wr_next,
    input  logic [PTR_W-1:0]   rd_ptr,
    output logic [PID_W-1:0]   rd_pid,
    output logic [VPN_W-1:0]   rd_vpn,
    output logic [PTR_W-1:0]   rd_next
);
    localparam logic [PTR_W-1:0] NIL = {PTR_W{1'b1}};

    logic [PID_W-1:0] own_pid [FRAMES];
    logic [VPN_W-1:0] own_vpn [FRAMES];
    logic [PTR_W-1:0] link    [FRAMES];

    // Purpose: load one frame entry per insert.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            own_pid[wr_frame] <= wr_pid;
            own_vpn[wr_frame] <= wr_vpn;
            link[wr_frame]    <= wr_next;
        end
    end

    logic out_of_range;
    assign out_of_range = rd_ptr[PTR_W-1];

    // Purpose: combinational read of the entry under the walk pointer.
    always_comb begin
        if (out_of_range) begin
            rd_pid  = '0;
            rd_vpn  = '0;
            rd_next = NIL;
        end else begin
            rd_pid  = own_pid[rd_ptr[FRAME_W-1:0]];
            rd_vpn  = own_vpn[rd_ptr[FRAME_W-1:0]];
            rd_next = link[rd_ptr[FRAME_W-1:0]];
        end
    end
endmodule

// File: rtl/ipt_walker.sv
// Module: ipt_walker
// Follows one chain, one entry per cycle. It stops on a nil pointer
// (miss), on a full key match (hit) or when the link budget is spent
// (miss). It emits a registered single-cycle response.
// Assumes start is raised only while idle.
module ipt_walker #(
    parameter int FRAMES = 256,
    parameter int PTR_W  = 9,
    parameter int PID_W  = 8,
    parameter int VPN_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PTR_W-1:0] start_ptr,
    input  logic [PID_W-1:0] key_pid_in,
    input  logic [VPN_W-1:0] key_vpn_in,
    input  logic [PID_W-1:0] ent_pid,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [PTR_W-1:0] ent_next,
    output logic [PTR_W-1:0] cur_ptr,
    output logic             busy,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic [PTR_W-1:0] resp_frame
);
    import ipt_pkg::*;

    localparam int               CNT_W = $clog2(FRAMES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAMES);
    localparam logic [PTR_W-1:0] NIL   = {PTR_W{1'b1}};

    walk_state_e      state;
    logic [CNT_W-1:0] links;
    logic [PID_W-1:0] key_pid;
    logic [VPN_W-1:0] key_vpn;
    logic             match;

    // Purpose: compare the full key against the entry under the pointer.
    assign match = (ent_pid == key_pid) && (ent_vpn == key_vpn);

    // Purpose: sequence the walk and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WALK_IDLE;
            cur_ptr    <= NIL;
            links      <= '0;
            key_pid    <= '0;
            key_vpn    <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_frame <= NIL;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                WALK_IDLE: begin
                    if (start) begin
                        cur_ptr <= start_ptr;
                        key_pid <= key_pid_in;
                        key_vpn <= key_vpn_in;
                        links   <= '0;
                        state   <= WALK_BUSY;
                    end
                end
                default: begin
                    if (cur_ptr == NIL || links == LIMIT) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_frame <= NIL;
                        state      <= WALK_IDLE;
                    end else if (match) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_frame <= cur_ptr;
                        state      <= WALK_IDLE;
                    end else begin
                        cur_ptr <= ent_next;
                        links   <= links + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (state == WALK_BUSY);

    // R7: the link counter never passes the budget
    assert_link_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        links <= LIMIT);
    // R10: the response strobe never lasts two cycles
    assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R10: a hit never reports the nil code, a miss always does
    assert_hit_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_hit == (resp_frame != NIL)));
    // R6: a walk that did not finish keeps the engine busy
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !resp_valid && $past(busy)) |-> $stable(key_pid));
endmodule

// File: rtl/inv_pt_lookup.sv
// Module: inv_pt_lookup (top)
// Hashed inverted page table lookup. It hashes the VPN into an anchor
// table, then walks the chain of frame entries. Inserts are put at the
// head of their bucket's chain.
// Assumes software never re-inserts a frame that is still linked into a
// chain; doing so can form a loop, which the link budget then cuts off.
module inv_pt_lookup #(
    parameter int FRAMES = 256,
    parameter int PID_W  = 8,
    parameter int VPN_W  = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [PID_W-1:0]           req_pid,
    input  logic [VPN_W-1:0]           req_vpn,
    input  logic                       ins_valid,
    input  logic [$clog2(FRAMES)-1:0]  ins_frame,
    input  logic [PID_W-1:0]           ins_pid,
    input  logic [VPN_W-1:0]           ins_vpn,
    output logic                       ready,
    output logic                       resp_valid,
    output logic                       resp_hit,
    output logic [$clog2(FRAMES):0]    resp_frame
);
    localparam int FRAME_W = $clog2(FRAMES);
    localparam int PTR_W   = FRAME_W + 1;
    localparam int HASH_W  = FRAME_W;

    logic              busy;
    logic              do_insert;
    logic              do_lookup;
    logic [HASH_W-1:0] ins_hash;
    logic [HASH_W-1:0] req_hash;
    logic [HASH_W-1:0] anchor_idx;
    logic [PTR_W-1:0]  anchor_ptr;
    logic [PTR_W-1:0]  walk_ptr;
    logic [PID_W-1:0]  ent_pid;
    logic [VPN_W-1:0]  ent_vpn;
    logic [PTR_W-1:0]  ent_next;

    // Purpose: fold the low two bytes of each VPN into a bucket index.
    assign ins_hash = ins_vpn[HASH_W-1:0] ^ ins_vpn[2*HASH_W-1:HASH_W];
    assign req_hash = req_vpn[HASH_W-1:0] ^ req_vpn[2*HASH_W-1:HASH_W];

    // Purpose: admit work only while idle; an insert wins over a lookup.
    assign ready     = !busy;
    assign do_insert = ins_valid && ready;
    assign do_lookup = req_valid && ready && !ins_valid;
    assign anchor_idx = do_insert ? ins_hash : req_hash;

    ipt_anchor_table #(
        .HASH_W (HASH_W),
        .PTR_W  (PTR_W)
    ) u_anchor (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (anchor_idx),
        .rd_ptr (anchor_ptr),
        .wr_en  (do_insert),
        .wr_idx (ins_hash),
        .wr_ptr ({1'b0, ins_frame})
    );

    ipt_frame_table #(
        .FRAMES  (FRAMES),
        .FRAME_W (FRAME_W),
        .PTR_W   (PTR_W),
        .PID_W   (PID_W),
        .VPN_W   (VPN_W)
    ) u_frames (
        .clk      (clk),
        .wr_en    (do_insert),
        .wr_frame (ins_frame),
        .wr_pid   (ins_pid),
        .wr_vpn   (ins_vpn),
        .wr_next  (anchor_ptr),
        .rd_ptr   (walk_ptr),
        .rd_pid   (ent_pid),
        .rd_vpn   (ent_vpn),
        .rd_next  (ent_next)
    );

    ipt_walker #(
        .FRAMES (FRAMES),
        .PTR_W  (PTR_W),
        .PID_W  (PID_W),
        .VPN_W  (VPN_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (do_lookup),
        .start_ptr  (anchor_ptr),
        .key_pid_in (req_pid),
        .key_vpn_in (req_vpn),
        .ent_pid    (ent_pid),
        .ent_vpn    (ent_vpn),
        .ent_next   (ent_next),
        .cur_ptr    (walk_ptr),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_frame (resp_frame)
    );

    // R9: an insert completes in one cycle and leaves the engine idle
    assert_insert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ready) |=> (ready && !resp_valid));
    // R6: an accepted lookup drops ready on the next cycle
    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ins_valid && ready) |=> !ready);
    // R8: no response appears without a walk having started
    assert_resp_needs_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(busy));
endmodule

// File: tb/inv_pt_lookup_test.sv
module inv_pt_lookup_test;
    localparam int CLK_PERIOD = 10;
    localparam int NIL = 511;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_pid = '0;
    logic [19:0] req_vpn = '0;
    logic        ins_valid = 1'b0;
    logic [7:0]  ins_frame = '0;
    logic [7:0]  ins_pid = '0;
    logic [19:0] ins_vpn = '0;
    logic        ready;
    logic        resp_valid;
    logic        resp_hit;
    logic [8:0]  resp_frame;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // behavioural reference state
    int m_anchor [256];
    int m_pid [256];
    int m_vpn [256];
    int m_next [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    inv_pt_lookup uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_pid(req_pid), .req_vpn(req_vpn),
        .ins_valid(ins_valid), .ins_frame(ins_frame), .ins_pid(ins_pid), .ins_vpn(ins_vpn),
        .ready(ready), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_frame(resp_frame)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int hash_of(input int vpn);
        return (vpn & 255) ^ ((vpn >> 8) & 255);
    endfunction

    task automatic model_insert(input int f, input int pid, input int vpn);
        int h = hash_of(vpn);
        m_pid[f] = pid;
        m_vpn[f] = vpn;
        m_next[f] = m_anchor[h];
        m_anchor[h] = f;
    endtask

    // walk the reference chain: result and cycles after the accepting edge
    task automatic model_walk(input int pid, input int vpn,
                              output bit hit, output int frame, output int lat);
        int p = m_anchor[hash_of(vpn)];
        int n = 0;
        hit = 0; frame = NIL; lat = 0;
        forever begin
            if (p == NIL || n == 256) begin lat = n + 1; return; end
            if (m_pid[p] == pid && m_vpn[p] == vpn) begin
                hit = 1; frame = p; lat = n + 1; return;
            end
            p = m_next[p];
            n++;
        end
    endtask

    task automatic do_insert(input int f, input int pid, input int vpn, input string req);
        @(negedge clk);
        ins_valid = 1; ins_frame = 8'(f); ins_pid = 8'(pid); ins_vpn = 20'(vpn);
        @(negedge clk);
        ins_valid = 0;
        model_insert(f, pid, vpn);
        check(ready === 1'b1 && resp_valid === 1'b0, req, "idle after insert",
              int'(ready), 1);
    endtask

    // lookup compared against the model on every clock until the response
    task automatic do_lookup(input int pid, input int vpn, input string req,
                             input bit stray);
        bit eh; int ef; int lat;
        model_walk(pid, vpn, eh, ef, lat);
        @(negedge clk);
        check(resp_valid === 1'b0, "R10", "no strobe before request", int'(resp_valid), 0);
        req_valid = 1; req_pid = 8'(pid); req_vpn = 20'(vpn);
        @(negedge clk);
        req_valid = 0;
        if (stray) begin
            ins_valid = 1; ins_frame = 8'd20; ins_pid = 8'd3; ins_vpn = 20'h00033;
            req_valid = 1; req_pid = 8'd3; req_vpn = 20'h00033;
        end
        check(resp_valid === 1'b0 && ready === 1'b0, "R6", "busy after accept",
              int'(ready), 0);
        for (int i = 1; i <= lat; i++) begin
            @(negedge clk);
            if (stray) begin ins_valid = 0; req_valid = 0; end
            if (i < lat) begin
                check(resp_valid === 1'b0 && ready === 1'b0, req, "early response",
                      int'(resp_valid), 0);
            end else begin
                check(resp_valid === 1'b1, req, "response cycle", int'(resp_valid), 1);
                check(resp_hit === eh, req, "hit flag", int'(resp_hit), int'(eh));
                check(int'(resp_frame) == ef, req, "frame", int'(resp_frame), ef);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) m_anchor[i] = NIL;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state and empty table
        check(ready === 1'b1, "R1", "ready after reset", int'(ready), 1);
        check(resp_valid === 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);
        do_lookup(1, 'h12345, "R1", 0);
        // R2 / R10: single entry hit
        do_insert(5, 1, 'h00102, "R3");
        do_lookup(1, 'h00102, "R2", 0);
        // R3 / R6: colliding entry goes to the head
        do_insert(7, 1, 'h00201, "R3");
        do_lookup(1, 'h00102, "R6", 0);
        do_lookup(1, 'h00201, "R3", 0);
        // R4: process ID must match too
        do_lookup(2, 'h00102, "R4", 0);
        // R11: high bits matter for the match, not for the hash
        do_lookup(1, 'h10102, "R11", 0);
        do_insert(9, 2, 'h00102, "R3");
        do_lookup(2, 'h00102, "R4", 0);
        do_lookup(1, 'h00102, "R5", 0);
        // R8: strobes during a walk are ignored
        do_lookup(1, 'h00102, "R8", 1);
        do_lookup(3, 'h00033, "R8", 0);
        // R9: insert and lookup together; the lookup is dropped
        @(negedge clk);
        ins_valid = 1; ins_frame = 8'd30; ins_pid = 8'd4; ins_vpn = 20'h0ABCD;
        req_valid = 1; req_pid = 8'd1; req_vpn = 20'h00102;
        @(negedge clk);
        ins_valid = 0; req_valid = 0;
        model_insert(30, 4, 'h0ABCD);
        for (int i = 0; i < 3; i++) begin
            check(resp_valid === 1'b0 && ready === 1'b1, "R9", "dropped lookup",
                  int'(resp_valid), 0);
            @(negedge clk);
        end
        do_lookup(4, 'h0ABCD, "R9", 0);
        // R10: highest frame index is reported, distinct from nil
        do_insert(255, 6, 'h0FF00, "R10");
        do_lookup(6, 'h0FF00, "R10", 0);
        // R7: a self loop is cut off by the link budget
        do_insert(40, 5, 'h00505, "R7");
        do_insert(40, 5, 'h00505, "R7");
        do_lookup(5, 'h00505, "R7", 0);
        do_lookup(5, 'h00A0A, "R7", 0);
        do_lookup(1, 'h00102, "R5", 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule